// File: doc/BRIEF.md
# Multi-Slave Register-Driven SPI Master

This block is a master-mode serial peripheral controller behind a small host register file. The host writes a command byte, an address byte and a data byte, then writes the control register with its request bit set. The controller then runs a complete three-byte exchange on its own and needs no further host action. It drives a serial clock that it generates itself, sends each byte most significant bit first on one data line, and gathers a byte from the selected input line at the same time. The byte that arrives during the data phase is kept in a receive register.

All slaves share the serial clock and the data output. The control register selects which of five active-low chip selects goes low for the exchange and which of four serial inputs is sampled. A per-input enable mask can disable an input. The serial clock rate, idle polarity and sampling phase are programmable. A status bit and a one-cycle completion pulse tell the host when the exchange has ended.

Top module: `spi_multi_master`

## Requirements
- R1: After reset, every chip select is high, sclk is 0, busy and done are 0, and all four read addresses return 0.
- R2: A write to address 0 with bit 0 set while idle starts an exchange. busy rises in the next cycle, and read address 0 returns bit 0 = 1 for as long as the exchange runs.
- R3: mosi carries the command (write address 1), then the address (write address 2), then the data (write address 3). Each byte goes out MSB first, 24 bits in all.
- R4: Control bits [3:1] hold a chip-select number. Values 0..4 drive that one cs_n bit low for the whole exchange, and values 5..7 drive none low. At most one cs_n bit is ever low, and all are high while idle.
- R5: Control bits [5:4] choose which miso bit is sampled. The byte received during the third (data) byte is readable at read address 3.
- R6: Control bits [9:6] enable the inputs, one bit per input. If the selected input's enable bit is 0, the exchange still runs and read address 3 returns 0xFF.
- R7: Control bits [12:10] hold n. The serial clock half-period is 2^n system cycles, and busy stays high for exactly 49·2^n cycles. This covers half a period of chip-select lead, 48 clock edges, and half a period of trail.
- R8: Control bit 13 sets the level of sclk while idle. When bit 14 is 0, data is sampled on the leading edge and changed on the trailing edge. When bit 14 is 1, data is changed on the leading edge and sampled on the trailing edge.
- R9: done is high for exactly one cycle: the first cycle in which busy is low after an exchange. At that point all chip selects are already released.
- R10: Every register write that is sampled while busy is high is ignored. This includes a write sampled on the clock edge where the exchange completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 command, 2 address, 3 data |
| wr_data | input | 15 | Write value (bytes use bits [7:0]) |
| rd_addr | input | 2 | Read address: 0 control/status, 1 command, 2 address, 3 received byte |
| rd_data | output | 15 | Read value for rd_addr |
| sclk | output | 1 | Serial clock shared by all slaves |
| mosi | output | 1 | Serial data output shared by all slaves |
| cs_n | output | 5 | Active-low chip selects |
| miso | input | 4 | Serial data inputs |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same clock cycle: the completion of an exchange and a new host request. The bench provokes this with the fastest clock setting. It counts cycles from the start write so that a second request, aimed at a different chip select, is sampled on exactly the 49th cycle. It then checks three things:
- done still pulses;
- busy stays low and every chip select stays high afterwards;
- a command write made earlier during the exchange has not altered the command register.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  localparam int CS_N   = 5;
  localparam int IN_N   = 4;
  localparam int BW     = 8;
  localparam int NBYTES = 3;
  localparam int DIVW   = 3;
  localparam int ADDR_W = 2;

  localparam int CSW   = $clog2(CS_N);
  localparam int INW   = $clog2(IN_N);
  localparam int BITW  = $clog2(BW);
  localparam int EDGES = 2 * BW * NBYTES;
  localparam int PHW   = $clog2(EDGES + 1);
  localparam int BYW   = PHW - BITW - 1;
  localparam int CNTW  = 1 << DIVW;
  localparam int REQ_B  = 0;
  localparam int CFG_LO = 1;

  typedef struct packed {
    logic            pha;
    logic            pol;
    logic [DIVW-1:0] div;
    logic [IN_N-1:0] en;
    logic [INW-1:0]  insel;
    logic [CSW-1:0]  cssel;
  } cfg_t;

  localparam int CFGW   = $bits(cfg_t);
  localparam int HOST_W = CFGW + 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_CMD  = 2'd1,
    A_ADDR = 2'd2,
    A_DATA = 2'd3
  } reg_addr_e;

  typedef enum logic {S_IDLE, S_RUN} seq_state_e;

  // terminal count of the half-period counter: 2^div - 1
  function automatic logic [CNTW-1:0] half_minus1(input logic [DIVW-1:0] div);
    logic [CNTW-1:0] one;
    one = {{(CNTW-1){1'b0}}, 1'b1};
    return (one << div) - one;
  endfunction

  // byte sent in phase idx; phases past the last send zero
  function automatic logic [BW-1:0] pick_byte(input logic [BYW-1:0] idx,
                                              input logic [BW-1:0] b0,
                                              input logic [BW-1:0] b1,
                                              input logic [BW-1:0] b2);
    case (idx)
      BYW'(0): return b0;
      BYW'(1): return b1;
      BYW'(2): return b2;
      default: return '0;
    endcase
  endfunction

  // selected serial input, forced to 1 when disabled or out of range
  function automatic logic sel_input(input logic [IN_N-1:0] lines,
                                     input logic [IN_N-1:0] en,
                                     input logic [INW-1:0]  sel);
    logic r;
    r = 1'b1;
    for (int i = 0; i < IN_N; i++)
      if (sel == INW'(i) && en[i]) r = lines[i];
    return r;
  endfunction
endpackage

// File: rtl/spi_mm_regs.sv
module spi_mm_regs
  import spi_mm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HOST_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic              rx_fire,
  input  logic [BW-1:0]     rx_word,
  output cfg_t              cfg,
  output logic [BW-1:0]     cmd_q,
  output logic [BW-1:0]     adr_q,
  output logic [BW-1:0]     dat_q,
  output logic              start,
  output logic [HOST_W-1:0] rd_data
);
  logic          wr_ok;
  logic [BW-1:0] rx_q;

  assign wr_ok = wr_en && !busy;
  assign start = wr_ok && (wr_addr == A_CTRL) && wr_data[REQ_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      cmd_q <= '0;
      adr_q <= '0;
      dat_q <= '0;
      rx_q  <= '0;
    end else begin
      if (wr_ok) begin
        case (wr_addr)
          A_CTRL:  cfg   <= wr_data[CFG_LO +: CFGW];
          A_CMD:   cmd_q <= wr_data[BW-1:0];
          A_ADDR:  adr_q <= wr_data[BW-1:0];
          default: dat_q <= wr_data[BW-1:0];
        endcase
      end
      if (rx_fire) rx_q <= rx_word;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {cfg, busy};
      A_CMD:   rd_data = HOST_W'(cmd_q);
      A_ADDR:  rd_data = HOST_W'(adr_q);
      default: rd_data = HOST_W'(rx_q);
    endcase
  end
endmodule

// File: rtl/spi_mm_clkgen.sv
module spi_mm_clkgen
  import spi_mm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] lim;

  assign lim  = half_minus1(div);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (restart || !run || tick) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_mm_seq.sv
module spi_mm_seq
  import spi_mm_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           tick,
  output logic           busy,
  output logic           done,
  output logic           lvl,
  output logic           edge_go,
  output logic           finish,
  output logic [PHW-1:0] ph
);
  seq_state_e state;

  assign busy    = (state == S_RUN);
  assign edge_go = busy && tick && (ph != PHW'(EDGES));
  assign finish  = busy && tick && (ph == PHW'(EDGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ph    <= '0;
      lvl   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= finish;
      if (start) begin
        state <= S_RUN;
        ph    <= '0;
        lvl   <= 1'b0;
      end else if (edge_go) begin
        ph  <= ph + 1'b1;
        lvl <= ~lvl;
      end else if (finish) begin
        state <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter
  import spi_mm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            edge_go,
  input  logic [PHW-1:0]  ph,
  input  cfg_t            cfg,
  input  logic [BW-1:0]   cmd_q,
  input  logic [BW-1:0]   adr_q,
  input  logic [BW-1:0]   dat_q,
  input  logic [IN_N-1:0] miso,
  output logic            mosi,
  output logic            rx_fire,
  output logic [BW-1:0]   rx_word
);
  logic            lead;
  logic            smp_edge;
  logic            shf_edge;
  logic            last_bit;
  logic [BITW-1:0] bit_i;
  logic [BYW-1:0]  byte_i;
  logic            in_bit;
  logic            samp;
  logic [BW-1:0]   sh;

  assign lead     = ~ph[0];
  assign bit_i    = ph[BITW:1];
  assign byte_i   = ph[PHW-1:BITW+1];
  assign smp_edge = edge_go && (cfg.pha ? !lead : lead);
  assign shf_edge = edge_go && (cfg.pha ? lead : !lead);
  assign last_bit = (bit_i == BITW'(BW-1));
  assign in_bit   = sel_input(miso, cfg.en, cfg.insel);
  assign mosi     = sh[BW-1];

  // with late phase the final bit is taken live on the sampling edge
  assign rx_word = cfg.pha ? {sh[BW-2:0], in_bit} : {sh[BW-2:0], samp};
  assign rx_fire = last_bit && (byte_i == BYW'(NBYTES-1)) &&
                   (cfg.pha ? smp_edge : shf_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      samp <= 1'b0;
    end else if (start) begin
      sh <= cmd_q;
    end else begin
      if (smp_edge) samp <= in_bit;
      if (shf_edge) begin
        if (cfg.pha)
          sh <= (bit_i == '0) ? pick_byte(byte_i, cmd_q, adr_q, dat_q)
                              : {sh[BW-2:0], samp};
        else
          sh <= last_bit ? pick_byte(byte_i + 1'b1, cmd_q, adr_q, dat_q)
                         : {sh[BW-2:0], samp};
      end
    end
  end
endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master
  import spi_mm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HOST_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [HOST_W-1:0] rd_data,
  output logic              sclk,
  output logic              mosi,
  output logic [CS_N-1:0]   cs_n,
  input  logic [IN_N-1:0]   miso,
  output logic              busy,
  output logic              done
);
  cfg_t           cfg;
  logic [BW-1:0]  cmd_q, adr_q, dat_q;
  logic           start, tick, lvl, edge_go, finish;
  logic [PHW-1:0] ph;
  logic           rx_fire;
  logic [BW-1:0]  rx_word;
  logic           cfg_pol;

  assign cfg_pol = cfg.pol;

  spi_mm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .busy(busy),
    .rx_fire(rx_fire), .rx_word(rx_word), .cfg(cfg),
    .cmd_q(cmd_q), .adr_q(adr_q), .dat_q(dat_q),
    .start(start), .rd_data(rd_data)
  );

  spi_mm_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(start),
    .div(cfg.div), .tick(tick)
  );

  spi_mm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .busy(busy), .done(done), .lvl(lvl), .edge_go(edge_go),
    .finish(finish), .ph(ph)
  );

  spi_mm_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .start(start), .edge_go(edge_go),
    .ph(ph), .cfg(cfg), .cmd_q(cmd_q), .adr_q(adr_q), .dat_q(dat_q),
    .miso(miso), .mosi(mosi), .rx_fire(rx_fire), .rx_word(rx_word)
  );

  assign sclk = lvl ^ cfg.pol;

  for (genvar g = 0; g < CS_N; g++) begin : g_cs
    assign cs_n[g] = !(busy && (cfg.cssel == CSW'(g)));
  end
endmodule

// File: rtl/spi_mm_checker.sv
module spi_mm_checker
  import spi_mm_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            sclk,
  input logic [CS_N-1:0] cs_n,
  input logic            cfg_pol,
  input logic            tick,
  input logic            start,
  input logic            wr_en,
  input logic [BW-1:0]   cmd_q,
  input cfg_t            cfg_bits
);
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  a_r4_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r4_cs_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));

  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_pol));

  a_r7_edge_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sclk));

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(cmd_q) && $stable(cfg_bits)));
endmodule

bind spi_multi_master spi_mm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sclk(sclk),
  .cs_n(cs_n), .cfg_pol(cfg_pol), .tick(tick), .start(start),
  .wr_en(wr_en), .cmd_q(cmd_q), .cfg_bits(cfg)
);

// File: tb/spi_multi_master_test.sv
module spi_multi_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [14:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [14:0] rd_data;
  logic        sclk, mosi, busy, done;
  logic [4:0]  cs_n;
  logic [3:0]  miso;
  logic        sbit = 1'b0;
  int          cur_in = 0;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  spi_multi_master uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso),
    .busy(busy), .done(done)
  );

  // slave model: selected line carries the pattern, the others its inverse
  always_comb
    for (int i = 0; i < 4; i++) miso[i] = (i == cur_in) ? sbit : ~sbit;

  // div, pol, pha, cs, insel, en, cmd, addr, data, slave pattern
  localparam int NV = 6;
  localparam logic [61:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b0, 3'd0, 2'd0, 4'hF, 8'hA5, 8'h3C, 8'h96, 24'h123456},
    {3'd1, 1'b1, 1'b0, 3'd1, 2'd1, 4'hF, 8'h01, 8'h80, 8'hFF, 24'hABCDEF},
    {3'd2, 1'b0, 1'b1, 3'd2, 2'd2, 4'hF, 8'hC3, 8'h7E, 8'h00, 24'h0F0F81},
    {3'd0, 1'b1, 1'b1, 3'd3, 2'd3, 4'hF, 8'h5A, 8'h11, 8'hEE, 24'h55AA3C},
    {3'd3, 1'b0, 1'b0, 3'd4, 2'd1, 4'hD, 8'h99, 8'h22, 8'h44, 24'h000000},
    {3'd7, 1'b1, 1'b1, 3'd6, 2'd0, 4'h1, 8'h12, 8'h34, 8'h56, 24'h9A0B18}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] ctrl(input int div, input bit pol, input bit pha,
                                       input int cs, input int insel,
                                       input logic [3:0] en, input bit req);
    return {pha, pol, 3'(div), en, 2'(insel), 3'(cs), req};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [14:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [14:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic run_txn(input int div, input bit pol, input bit pha, input int cs,
                         input int insel, input logic [3:0] en,
                         input logic [7:0] c, input logic [7:0] a,
                         input logic [7:0] dt, input logic [23:0] pat);
    logic [23:0] got;
    logic [14:0] r;
    logic [4:0]  exp_cs;
    logic [7:0]  exp_rx;
    logic        prev, lead;
    int k, edges, samples, cycles, csbad, donebad, rqbad;
    exp_cs = (cs < 5) ? ~(5'b1 << cs) : 5'h1F;
    exp_rx = en[insel] ? pat[7:0] : 8'hFF;
    wr(2'd1, 15'(c));
    wr(2'd2, 15'(a));
    wr(2'd3, 15'(dt));
    wr(2'd0, ctrl(div, pol, pha, cs, insel, en, 1'b0));
    chk(sclk === pol && busy === 1'b0, "R8 idle level before start", sclk, pol);
    cur_in = insel;
    sbit = pat[23];
    k = 0; edges = 0; samples = 0; cycles = 0;
    csbad = 0; donebad = 0; rqbad = 0; got = '0;
    prev = sclk;
    rd_addr = 2'd0;
    wr(2'd0, ctrl(div, pol, pha, cs, insel, en, 1'b1));
    while (busy === 1'b1) begin
      cycles++;
      if (rd_data[0] !== 1'b1) rqbad++;
      if (cs_n !== exp_cs) csbad++;
      if (done !== 1'b0) donebad++;
      if (sclk !== prev) begin
        lead = (sclk !== pol);
        edges++;
        if (pha ? !lead : lead) begin
          got = {got[22:0], mosi};
          samples++;
        end else if (pha) begin
          if (k < 24) sbit = pat[23-k];
          k++;
        end else begin
          k++;
          if (k < 24) sbit = pat[23-k];
        end
        prev = sclk;
      end
      if (cycles > 20000) break;
      @(negedge clk);
    end
    chk(cycles == (49 << div), "R7 busy length", cycles, 49 << div);
    chk(got == {c, a, dt}, "R3 mosi bytes", got, {c, a, dt});
    chk(edges == 48 && samples == 24, "R8 edge count", edges, 48);
    chk(csbad == 0, "R4 chip select during exchange", csbad, 0);
    chk(rqbad == 0, "R2 request bit reads busy", rqbad, 0);
    chk(donebad == 0 && done === 1'b1, "R9 done at completion", done, 1);
    chk(cs_n === 5'h1F, "R9 cs released", cs_n, 5'h1F);
    chk(sclk === pol, "R8 idle level after", sclk, pol);
    rd(2'd3, r);
    chk(r == 15'(exp_rx), en[insel] ? "R5 received byte" : "R6 disabled input",
        r, exp_rx);
    rd(2'd0, r);
    chk(r[0] == 1'b0, "R2 request bit clears", r, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", done, 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : main
    logic [14:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n === 5'h1F, "R1 cs reset", cs_n, 5'h1F);
    chk(sclk === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 outputs reset",
        {sclk, busy, done}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk(r == '0, "R1 register reset", r, 0);
    end

    for (int v = 0; v < NV; v++)
      run_txn(int'(VEC[v][61:59]), VEC[v][58], VEC[v][57], int'(VEC[v][56:54]),
              int'(VEC[v][53:52]), VEC[v][51:48], VEC[v][47:40], VEC[v][39:32],
              VEC[v][31:24], VEC[v][23:0]);

    // R10: writes while busy, and a request landing on the completion edge
    wr(2'd1, 15'h03D);
    wr(2'd0, ctrl(0, 1'b0, 1'b0, 0, 0, 4'hF, 1'b1));
    repeat (4) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 15'h0EE;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (43) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = ctrl(0, 1'b0, 1'b0, 1, 0, 4'hF, 1'b1);
    @(negedge clk);
    wr_en = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R9 done on collision edge",
        {done, busy}, 2'b10);
    @(negedge clk);
    chk(busy === 1'b0, "R10 request on completion ignored", busy, 0);
    chk(cs_n === 5'h1F, "R10 no chip select after ignored request", cs_n, 5'h1F);
    rd(2'd1, r);
    chk(r == 15'h03D, "R10 command write while busy ignored", r, 15'h03D);
    rd(2'd0, r);
    chk(r[3:1] == 3'd0, "R10 control write while busy ignored", r[3:1], 0);

    summary();
    $finish;
  end
endmodule